// File: doc/BRIEF.md
# Split Scratchpad and Cache Instruction Fetch

This block sits between a processor's instruction-fetch port and a slower main-memory read port. It holds two on-chip stores whose sizes together make up one fixed storage budget: a tagless scratchpad RAM and a direct-mapped instruction cache with 32-byte lines. A range-lookup unit keeps a programmable address window, set by a lower and an upper bound register. Two comparators check every fetch address against both bounds in the same cycle. A fetch inside the window is served from the scratchpad. A fetch outside it goes through the cache.

A loader copies a block of instructions from main memory into the scratchpad and then writes the two bounds. After that it stays idle, and fetching does not depend on it. A cache miss stalls the fetch port while the whole line is refilled, one word at a time, from the line-aligned address upward. Statistics counters record fetches, scratchpad hits, cache misses, delivered instructions and elapsed cycles.

Top module: `ifetch_split`

## Requirements
- R1: After reset all event counters read zero, `rsp_valid` and `mem_req` are low, `fetch_ready` is high and the window is disabled, so a first fetch goes to the cache and misses.
- R2: The window test is inclusive at both ends (lower <= address <= upper). A fetch inside the window returns the scratchpad word at index (address - lower)/4, with `rsp_from_spm` = 1, in the cycle after acceptance.
- R3: A fetch served from the scratchpad issues no main-memory read.
- R4: A fetch outside the window that hits a valid cache line returns its word with `rsp_from_spm` = 0 in the cycle after acceptance.
- R5: On a cache miss `fetch_ready` stays low while exactly 8 word reads are issued at line base + 4*i for i = 0..7 in ascending order. The requested word is then returned with `rsp_from_spm` = 0.
- R6: A line's valid bit and tag are written only with its last refill word. A later fetch to any word of that line hits without a memory read.
- R7: The cache is direct-mapped, with index = address bits [7:5] and tag = bits [31:8] at default sizes. Two addresses with the same index and different tags evict each other.
- R8: A load request copies n words from source + 4*i into scratchpad index i, where n = (upper - lower)/4 + 1 capped at the scratchpad depth. The bounds take effect only when the copy ends. While loading, `ld_busy` is high, `fetch_ready` is low and no scratchpad hit is reported.
- R9: If the bounds hold lower > upper, no fetch is served from the scratchpad and the loader reads no words.
- R10: The counters count accepted fetches, scratchpad-served fetches, cache misses, delivered responses, and one per clock cycle since reset.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fetch_valid | input | 1 | Fetch request present |
| fetch_addr | input | 32 | Byte address of the fetch, word aligned |
| fetch_ready | output | 1 | Fetch accepted when high with fetch_valid |
| rsp_valid | output | 1 | One-cycle pulse with the fetched word |
| rsp_data | output | 32 | Fetched instruction word |
| rsp_from_spm | output | 1 | Word came from the scratchpad |
| mem_req | output | 1 | Main-memory word read request, held until mem_rvalid |
| mem_addr | output | 32 | Byte address of the memory read |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 32 | Read data |
| ld_start | input | 1 | Start a scratchpad load (taken while no fill runs) |
| ld_src | input | 32 | Main-memory source address of the block |
| ld_lo | input | 32 | New lower window bound |
| ld_hi | input | 32 | New upper window bound |
| ld_busy | output | 1 | Load in progress |
| cnt_fetch | output | 32 | Accepted fetches |
| cnt_spm | output | 32 | Fetches served from the scratchpad |
| cnt_miss | output | 32 | Cache misses |
| cnt_issue | output | 32 | Responses delivered |
| cnt_cycle | output | 32 | Cycles since reset |

## Verification
The embedded assertions watch every cycle for several properties. No window hit may appear during a load or under inverted bounds. A scratchpad-served fetch must never be followed by a memory read. Every hit must answer in the next cycle, and the fetch port must stay stalled during a refill. A partly refilled line must stay invalid until its last word, and the scratchpad count must never pass the fetch count. Other behaviour shows only in the bench scenarios. Those are the data returned at both inclusive bounds and just outside them, the exact ascending refill address sequence, eviction between two lines that share an index, the bounds taking effect after a copy, and the counter totals.

// File: rtl/ifs_pkg.sv
package ifs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_LOAD = 2'd2
    } fsm_e;
endpackage

// File: rtl/ifs_window.sv
module ifs_window #(
    parameter int AW        = 32,
    parameter int SPM_WORDS = 64,
    parameter int IDX_W     = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             set,
    input  logic [AW-1:0]    set_lo,
    input  logic [AW-1:0]    set_hi,
    input  logic [AW-1:0]    addr,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    typedef struct packed {
        logic          en;
        logic [AW-1:0] lo;
        logic [AW-1:0] hi;
    } win_t;

    win_t win_d, win_q;
    logic          ge_lo, le_hi, in_cap;
    logic [AW-1:0] off, word;

    always_comb begin
        // both bound comparators evaluated in parallel
        ge_lo  = (addr >= win_q.lo);
        le_hi  = (addr <= win_q.hi);
        off    = addr - win_q.lo;
        word   = off >> 2;
        in_cap = (word < AW'(SPM_WORDS));
        hit    = win_q.en && ge_lo && le_hi && in_cap;
        idx    = word[IDX_W-1:0];

        win_d = win_q;
        if (clr) begin
            win_d.en = 1'b0;
        end else if (set) begin
            win_d.en = 1'b1;
            win_d.lo = set_lo;
            win_d.hi = set_hi;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

    AST_INVERTED_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (win_q.lo > win_q.hi) |-> !hit); // R9
endmodule

// File: rtl/ifs_spm.sv
module ifs_spm #(
    parameter int DW    = 32,
    parameter int WORDS = 64,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [DW-1:0]    wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [DW-1:0]    rdata
);
    logic [DW-1:0] mem_q [WORDS];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/ifs_dcache.sv
module ifs_dcache #(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int LINES = 8,
    parameter int WPL   = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] lk_addr,
    output logic          hit,
    output logic [DW-1:0] rdata,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          fill_done,
    input  logic [AW-1:0] fill_addr
);
    localparam int OFF_W = $clog2(WPL);
    localparam int IDX_W = $clog2(LINES);
    localparam int LB    = 2 + OFF_W;
    localparam int TAG_W = AW - LB - IDX_W;

    logic [DW-1:0]    data_q [LINES*WPL];
    logic [TAG_W-1:0] tag_q  [LINES];
    logic [LINES-1:0] vld_d, vld_q;

    logic [IDX_W-1:0] lk_idx, w_idx, f_idx;
    logic [OFF_W-1:0] lk_off, w_off;
    logic [TAG_W-1:0] lk_tag, f_tag;
    logic             unused_bits;

    assign lk_idx = lk_addr[LB +: IDX_W];
    assign lk_off = lk_addr[2 +: OFF_W];
    assign lk_tag = lk_addr[AW-1 -: TAG_W];
    assign w_idx  = wr_addr[LB +: IDX_W];
    assign w_off  = wr_addr[2 +: OFF_W];
    assign f_idx  = fill_addr[LB +: IDX_W];
    assign f_tag  = fill_addr[AW-1 -: TAG_W];
    assign unused_bits = ^{lk_addr[1:0], wr_addr[1:0], wr_addr[AW-1 -: TAG_W],
                           fill_addr[LB-1:0]};

    assign hit   = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
    assign rdata = data_q[{lk_idx, lk_off}];

    always_comb begin
        vld_d = vld_q;
        if (wr_en)     vld_d[w_idx] = 1'b0;
        if (fill_done) vld_d[f_idx] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= vld_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en)     data_q[{w_idx, w_off}] <= wr_data;
        if (fill_done) tag_q[f_idx]           <= f_tag;
    end

    AST_FILL_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |=> vld_q[$past(f_idx)]); // R6
    AST_PARTIAL_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !fill_done) |=> !vld_q[$past(w_idx)]); // R6
endmodule

// File: rtl/ifs_counters.sv
module ifs_counters #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc_fetch,
    input  logic          inc_spm,
    input  logic          inc_miss,
    input  logic          inc_issue,
    output logic [CW-1:0] cnt_fetch,
    output logic [CW-1:0] cnt_spm,
    output logic [CW-1:0] cnt_miss,
    output logic [CW-1:0] cnt_issue,
    output logic [CW-1:0] cnt_cycle
);
    typedef struct packed {
        logic [CW-1:0] fetch;
        logic [CW-1:0] spm;
        logic [CW-1:0] miss;
        logic [CW-1:0] issue;
        logic [CW-1:0] cycle;
    } cnt_t;

    cnt_t c_d, c_q;

    always_comb begin
        c_d       = c_q;
        c_d.cycle = c_q.cycle + CW'(1);
        if (inc_fetch) c_d.fetch = c_q.fetch + CW'(1);
        if (inc_spm)   c_d.spm   = c_q.spm   + CW'(1);
        if (inc_miss)  c_d.miss  = c_q.miss  + CW'(1);
        if (inc_issue) c_d.issue = c_q.issue + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign cnt_fetch = c_q.fetch;
    assign cnt_spm   = c_q.spm;
    assign cnt_miss  = c_q.miss;
    assign cnt_issue = c_q.issue;
    assign cnt_cycle = c_q.cycle;

    AST_SPM_LE_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.spm <= c_q.fetch); // R10
    AST_MISS_LE_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.miss <= c_q.fetch); // R10
endmodule

// File: rtl/ifetch_split.sv
module ifetch_split
    import ifs_pkg::*;
#(
    parameter int AW           = 32,
    parameter int DW           = 32,
    parameter int BUDGET_BYTES = 512,
    parameter int SPM_BYTES    = 256,
    parameter int LINE_BYTES   = 32,
    parameter int CW           = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fetch_valid,
    input  logic [AW-1:0] fetch_addr,
    output logic          fetch_ready,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic          rsp_from_spm,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_rvalid,
    input  logic [DW-1:0] mem_rdata,
    input  logic          ld_start,
    input  logic [AW-1:0] ld_src,
    input  logic [AW-1:0] ld_lo,
    input  logic [AW-1:0] ld_hi,
    output logic          ld_busy,
    output logic [CW-1:0] cnt_fetch,
    output logic [CW-1:0] cnt_spm,
    output logic [CW-1:0] cnt_miss,
    output logic [CW-1:0] cnt_issue,
    output logic [CW-1:0] cnt_cycle
);
    localparam int CACHE_BYTES = BUDGET_BYTES - SPM_BYTES;
    localparam int WB          = DW / 8;
    localparam int WPL         = LINE_BYTES / WB;
    localparam int LINES       = CACHE_BYTES / LINE_BYTES;
    localparam int SPM_WORDS   = SPM_BYTES / WB;
    localparam int OFF_W       = $clog2(WPL);
    localparam int LB          = 2 + OFF_W;
    localparam int SIDX_W      = $clog2(SPM_WORDS);
    localparam int LN_W        = SIDX_W + 1;

    typedef struct packed {
        fsm_e            st;
        logic            rsp_v;
        logic [DW-1:0]   rsp_d;
        logic            rsp_s;
        logic [AW-1:0]   base;
        logic [OFF_W-1:0] req_off;
        logic [OFF_W-1:0] fwc;
        logic [DW-1:0]   capt;
        logic [AW-1:0]   src;
        logic [AW-1:0]   lo;
        logic [AW-1:0]   hi;
        logic [LN_W-1:0] n;
        logic [LN_W-1:0] lwc;
    } top_t;

    top_t s_d, s_q;

    logic              accept, win_hit, c_hit;
    logic [SIDX_W-1:0] win_idx;
    logic [DW-1:0]     spm_rdata, c_rdata;
    logic              win_clr, win_set, spm_we, c_wr, c_fill;
    logic              inc_fetch, inc_spm, inc_miss;
    logic [AW-1:0]     span;
    logic [LN_W-1:0]   n_calc;

    assign fetch_ready  = (s_q.st == ST_IDLE) && !ld_start;
    assign accept       = fetch_valid && fetch_ready;
    assign rsp_valid    = s_q.rsp_v;
    assign rsp_data     = s_q.rsp_d;
    assign rsp_from_spm = s_q.rsp_s;
    assign ld_busy      = (s_q.st == ST_LOAD);
    assign mem_req      = (s_q.st == ST_FILL) || ((s_q.st == ST_LOAD) && (s_q.n != '0));

    always_comb begin
        if (s_q.st == ST_LOAD)
            mem_addr = s_q.src + {{(AW-LN_W-2){1'b0}}, s_q.lwc, 2'b00};
        else
            mem_addr = s_q.base + {{(AW-OFF_W-2){1'b0}}, s_q.fwc, 2'b00};
    end

    always_comb begin
        span = (ld_hi - ld_lo) >> 2;
        if (ld_lo > ld_hi)                  n_calc = '0;
        else if (span >= AW'(SPM_WORDS))    n_calc = LN_W'(SPM_WORDS);
        else                                n_calc = LN_W'(span + AW'(1));
    end

    always_comb begin
        s_d       = s_q;
        s_d.rsp_v = 1'b0;
        win_clr   = 1'b0;
        win_set   = 1'b0;
        spm_we    = 1'b0;
        c_wr      = 1'b0;
        c_fill    = 1'b0;
        inc_fetch = 1'b0;
        inc_spm   = 1'b0;
        inc_miss  = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (ld_start) begin
                    s_d.st  = ST_LOAD;
                    s_d.src = ld_src;
                    s_d.lo  = ld_lo;
                    s_d.hi  = ld_hi;
                    s_d.n   = n_calc;
                    s_d.lwc = '0;
                    win_clr = 1'b1;
                end else if (accept) begin
                    inc_fetch = 1'b1;
                    if (win_hit) begin
                        inc_spm   = 1'b1;
                        s_d.rsp_v = 1'b1;
                        s_d.rsp_d = spm_rdata;
                        s_d.rsp_s = 1'b1;
                    end else if (c_hit) begin
                        s_d.rsp_v = 1'b1;
                        s_d.rsp_d = c_rdata;
                        s_d.rsp_s = 1'b0;
                    end else begin
                        inc_miss    = 1'b1;
                        s_d.st      = ST_FILL;
                        s_d.base    = {fetch_addr[AW-1:LB], {LB{1'b0}}};
                        s_d.req_off = fetch_addr[2 +: OFF_W];
                        s_d.fwc     = '0;
                    end
                end
            end
            ST_FILL: begin
                if (mem_rvalid) begin
                    c_wr = 1'b1;
                    if (s_q.fwc == s_q.req_off) s_d.capt = mem_rdata;
                    if (s_q.fwc == OFF_W'(WPL - 1)) begin
                        c_fill    = 1'b1;
                        s_d.st    = ST_IDLE;
                        s_d.rsp_v = 1'b1;
                        s_d.rsp_s = 1'b0;
                        s_d.rsp_d = (s_q.fwc == s_q.req_off) ? mem_rdata : s_q.capt;
                    end else begin
                        s_d.fwc = s_q.fwc + OFF_W'(1);
                    end
                end
            end
            ST_LOAD: begin
                if (s_q.n == '0) begin
                    win_set = 1'b1;
                    s_d.st  = ST_IDLE;
                end else if (mem_rvalid) begin
                    spm_we = 1'b1;
                    if (s_q.lwc == s_q.n - LN_W'(1)) begin
                        win_set = 1'b1;
                        s_d.st  = ST_IDLE;
                    end else begin
                        s_d.lwc = s_q.lwc + LN_W'(1);
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    ifs_window #(.AW(AW), .SPM_WORDS(SPM_WORDS), .IDX_W(SIDX_W)) u_win (
        .clk(clk), .rst_n(rst_n), .clr(win_clr), .set(win_set),
        .set_lo(s_q.lo), .set_hi(s_q.hi), .addr(fetch_addr),
        .hit(win_hit), .idx(win_idx)
    );

    ifs_spm #(.DW(DW), .WORDS(SPM_WORDS), .IDX_W(SIDX_W)) u_spm (
        .clk(clk), .we(spm_we), .waddr(s_q.lwc[SIDX_W-1:0]), .wdata(mem_rdata),
        .raddr(win_idx), .rdata(spm_rdata)
    );

    ifs_dcache #(.AW(AW), .DW(DW), .LINES(LINES), .WPL(WPL)) u_cache (
        .clk(clk), .rst_n(rst_n), .lk_addr(fetch_addr), .hit(c_hit), .rdata(c_rdata),
        .wr_en(c_wr), .wr_addr(mem_addr), .wr_data(mem_rdata),
        .fill_done(c_fill), .fill_addr(s_q.base)
    );

    ifs_counters #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .inc_fetch(inc_fetch), .inc_spm(inc_spm),
        .inc_miss(inc_miss), .inc_issue(s_q.rsp_v),
        .cnt_fetch(cnt_fetch), .cnt_spm(cnt_spm), .cnt_miss(cnt_miss),
        .cnt_issue(cnt_issue), .cnt_cycle(cnt_cycle)
    );

    AST_HIT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (win_hit || c_hit)) |=> rsp_valid); // R2
    AST_SPM_NO_MEMREAD: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && win_hit) |=> !mem_req); // R3
    AST_FILL_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_FILL) |-> !fetch_ready); // R5
    AST_LOAD_NO_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_LOAD) |-> (!win_hit && !fetch_ready)); // R8
endmodule

// File: tb/sim_ifetch_split.sv
`timescale 1ns/1ps
module sim_ifetch_split;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        fetch_ready, rsp_valid, rsp_from_spm, mem_req, ld_busy;
    logic [31:0] rsp_data, mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        ld_start = 1'b0;
    logic [31:0] ld_src = '0, ld_lo = '0, ld_hi = '0;
    logic [31:0] cnt_fetch, cnt_spm, cnt_miss, cnt_issue, cnt_cycle;

    int checks = 0;
    int errors = 0;
    int n_fetch = 0, n_spm = 0, n_miss = 0;
    logic [31:0] exp_d_q[$];
    logic        exp_s_q[$];
    string       exp_r_q[$];
    logic [31:0] req_log[$];

    always #2.5 clk = ~clk;

    ifetch_split u0 (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .fetch_ready(fetch_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rsp_from_spm(rsp_from_spm), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .ld_start(ld_start),
        .ld_src(ld_src), .ld_lo(ld_lo), .ld_hi(ld_hi), .ld_busy(ld_busy),
        .cnt_fetch(cnt_fetch), .cnt_spm(cnt_spm), .cnt_miss(cnt_miss),
        .cnt_issue(cnt_issue), .cnt_cycle(cnt_cycle)
    );

    function automatic logic [31:0] memval(input logic [31:0] a);
        return {~a[15:0], a[15:0]};
    endfunction

    task automatic chk(input string req, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // main-memory model: two-cycle latency, one outstanding read
    bit          m_busy = 0;
    int          m_lat  = 0;
    logic [31:0] m_addr = '0;
    always @(negedge clk) begin
        mem_rvalid = 1'b0;
        if (!rst_n) begin
            m_busy = 0;
        end else if (m_busy) begin
            m_lat--;
            if (m_lat == 0) begin
                mem_rvalid = 1'b1;
                mem_rdata  = memval(m_addr);
                m_busy     = 0;
            end
        end else if (mem_req) begin
            m_busy = 1;
            m_lat  = 2;
            m_addr = mem_addr;
            req_log.push_back(mem_addr);
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_d_q.size() == 0) begin
                chk("R2", "unexpected response", 1, 0);
            end else begin
                logic [31:0] d;
                logic        s;
                string       r;
                d = exp_d_q.pop_front();
                s = exp_s_q.pop_front();
                r = exp_r_q.pop_front();
                chk(r, "response data", rsp_data, d);
                chk(r, "response source", rsp_from_spm, s);
            end
        end
    end

    task automatic do_fetch(input logic [31:0] a, input logic [31:0] d, input logic s,
                            input logic miss, input string req);
        int nlog;
        nlog = req_log.size();
        exp_d_q.push_back(d);
        exp_s_q.push_back(s);
        exp_r_q.push_back(req);
        n_fetch++;
        if (s) n_spm++;
        if (miss) n_miss++;
        @(negedge clk);
        fetch_valid = 1'b1;
        fetch_addr  = a;
        for (int i = 0; i < 1000 && !fetch_ready; i++) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        fetch_valid = 1'b0;
        if (miss) chk("R5", "stall during refill", fetch_ready, 0);
        else      chk(req, "response next cycle", rsp_valid, 1);
        for (int i = 0; i < 200 && exp_d_q.size() != 0; i++) @(negedge clk);
        chk(req, "response delivered", exp_d_q.size(), 0);
        if (miss) begin
            chk("R5", "refill read count", req_log.size() - nlog, 8);
            for (int i = 0; i < 8; i++)
                chk("R5", "refill address order", req_log[nlog + i],
                    {a[31:5], 5'b0} + 32'(4 * i));
        end else begin
            chk(s ? "R3" : "R6", "no memory read", req_log.size() - nlog, 0);
        end
    endtask

    task automatic do_load(input logic [31:0] src, input logic [31:0] lo,
                           input logic [31:0] hi, input int n);
        int nlog;
        nlog = req_log.size();
        @(negedge clk);
        ld_start = 1'b1; ld_src = src; ld_lo = lo; ld_hi = hi;
        @(posedge clk);
        @(negedge clk);
        ld_start = 1'b0;
        chk("R8", "busy while loading", ld_busy, 1);
        chk("R8", "fetch blocked while loading", fetch_ready, 0);
        for (int i = 0; i < 2000 && ld_busy; i++) @(negedge clk);
        chk("R8", "loader word count", req_log.size() - nlog, n);
        if (n > 0) begin
            chk("R8", "loader first address", req_log[nlog], src);
            chk("R8", "loader last address", req_log[nlog + n - 1], src + 32'(4 * (n - 1)));
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] c0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "fetch count", cnt_fetch, 0);
        chk("R1", "spm count", cnt_spm, 0);
        chk("R1", "miss count", cnt_miss, 0);
        chk("R1", "rsp_valid", rsp_valid, 0);
        chk("R1", "mem_req", mem_req, 0);
        chk("R1", "fetch_ready", fetch_ready, 1);
        // R1 window disabled: first fetch misses into cache (R5)
        do_fetch(32'h2000, memval(32'h2000), 1'b0, 1'b1, "R1");
        // R4/R6 hit on refilled line
        do_fetch(32'h2004, memval(32'h2004), 1'b0, 1'b0, "R4");
        do_fetch(32'h201C, memval(32'h201C), 1'b0, 1'b0, "R6");
        // R5 miss on a middle word
        do_fetch(32'h1014, memval(32'h1014), 1'b0, 1'b1, "R5");
        // R8 load 16 words into window 0x2000..0x203C
        do_load(32'h8000, 32'h2000, 32'h203C, 16);
        // R2 inclusive bounds, R3 no memory reads
        do_fetch(32'h2000, memval(32'h8000), 1'b1, 1'b0, "R2");
        do_fetch(32'h203C, memval(32'h803C), 1'b1, 1'b0, "R2");
        do_fetch(32'h2010, memval(32'h8010), 1'b1, 1'b0, "R3");
        // R2 just outside both bounds goes to cache
        do_fetch(32'h1FFC, memval(32'h1FFC), 1'b0, 1'b1, "R2");
        do_fetch(32'h2040, memval(32'h2040), 1'b0, 1'b1, "R2");
        // R7 same index, different tags evict each other
        do_fetch(32'h1104, memval(32'h1104), 1'b0, 1'b1, "R7");
        do_fetch(32'h1014, memval(32'h1014), 1'b0, 1'b1, "R7");
        do_fetch(32'h1018, memval(32'h1018), 1'b0, 1'b0, "R7");
        // R9 inverted bounds: no words loaded, window never hits
        do_load(32'h9000, 32'h3000, 32'h2FF0, 0);
        do_fetch(32'h2FF8, memval(32'h2FF8), 1'b0, 1'b1, "R9");
        do_fetch(32'h2000, memval(32'h2000), 1'b0, 1'b1, "R9");
        // R10 counters
        @(negedge clk);
        chk("R10", "fetch count", cnt_fetch, 32'(n_fetch));
        chk("R10", "spm count", cnt_spm, 32'(n_spm));
        chk("R10", "miss count", cnt_miss, 32'(n_miss));
        chk("R10", "issue count", cnt_issue, 32'(n_fetch));
        c0 = cnt_cycle;
        repeat (10) @(negedge clk);
        chk("R10", "cycle count", cnt_cycle - c0, 10);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule